// File: doc/BRIEF.md
# System Controller Register Bank

This block is the software-visible control page of a small system-on-chip. Accesses are 32-bit and word-aligned. The block turns each access into a register operation. It holds the general-purpose input, output and interrupt-enable words, and a debug scratch word. It also holds a one-way lock flag, a configuration-command register and three fixed identity words: clock frequency, capability bits and system identifier. The two timer register groups are not stored here. Accesses that land on them are forwarded to a separate timer block, and that block supplies the read data.

Some writes act as triggers. A matching command word written to the configuration-command register raises a one-cycle shutdown request. Any write to the system-identifier word raises a one-cycle system reset request and leaves the identifier unchanged. Writes to read-only words and any access to an unmapped word are flagged on a one-cycle error strobe and change no state. The general-purpose input word passes through a single register stage. The interrupt output is the OR of the input bits that are enabled.

Top module: `sysctl_regbank`

## Requirements
- R1: The word index is the byte address with its two low bits dropped, so the low two address bits have no effect. Mapped indexes: 0 input, 1 output, 2 interrupt enable, 4/5/6 and 8/9/10 timer, 16 command, 20 scratch, 21 lock, 29 frequency, 30 capabilities, 31 system identifier. The scratch word at index 20 reads back what was last written to it.
- R2: A request is sampled on a rising edge. On the next edge `rsp_valid` rises for one cycle, together with `rsp_rdata` and `err_strobe`. `rsp_rdata` is 0 for writes.
- R3: Any write to index 21 sets the lock flag to 1 whatever the data. Index 21 reads as 1 from then on, and only reset returns it to 0.
- R4: A write to index 16 whose data bits [15:0] equal 0x000E raises `shutdown_req` for exactly one cycle, in the cycle after the request. Any other data raises nothing. Index 16 reads as 0x00000001 (ready).
- R5: Any write to index 31 raises `sysreset_req` for exactly one cycle, in the cycle after the request. The identifier read back afterwards is unchanged.
- R6: Writes to indexes 0, 29 and 30 are ignored and raise `err_strobe`.
- R7: After reset, index 31 reads SYS_ID (default 0x10014D31), index 29 reads CLK_FREQ (default 80000000), index 30 reads CAPS (default 0), and index 0 reads GPIO_STRAP (default 1) until the first edge that samples the pins. All other stored words read 0.
- R8: A read or write to an unmapped index, including any index of 32 or more, returns 0, raises `err_strobe` and changes no stored word.
- R9: Index 0 returns the pin value captured one edge earlier. `gpio_out` is the low GPIO_W bits of index 1.
- R10: `gpio_irq` is 1 exactly when some bit is 1 in both the input register and the enable word at index 2.
- R11: An access to a timer index drives `tmr_valid` in the same cycle, with `tmr_group` = 0 for indexes 4..6 and 1 for indexes 8..10, and `tmr_reg` = index mod 4. The response carries `tmr_rdata` as it was at the sampling edge, and no error is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| err_strobe | output | 1 | Access error (unmapped, or a write to a read-only word) |
| gpio_pins | input | GPIO_W | Raw general-purpose inputs |
| gpio_out | output | GPIO_W | General-purpose outputs |
| gpio_irq | output | 1 | Input interrupt |
| shutdown_req | output | 1 | One-cycle shutdown request |
| sysreset_req | output | 1 | One-cycle system reset request |
| tmr_valid | output | 1 | Timer access forwarded |
| tmr_write | output | 1 | Forwarded access is a write |
| tmr_group | output | 1 | Timer group select |
| tmr_reg | output | 2 | Register within the timer group |
| tmr_wdata | output | 32 | Forwarded write data |
| tmr_rdata | input | 32 | Read data from the timer block |

## Verification
Two pairs of events can land in the same response cycle. A command write to index 16 must raise `shutdown_req` with a valid response and a clear error strobe. A write to the system identifier must raise `sysreset_req` with no error, although the identifier is otherwise read-only. The scoreboard stores every expected pulse and error bit with the expected read data, and compares all four at the response edge. Idle cycles are checked to carry no pulse. Near-miss command words (0x000F, and 0x000E placed in the upper half) must raise neither pulse.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int DATA_W = 32;
  localparam int MAP_W  = 5;

  typedef enum logic [3:0] {
    K_NONE, K_GIN, K_GOUT, K_GIEN, K_TMR, K_CMD,
    K_SCR, K_LOCK, K_FREQ, K_CAPS, K_SYSID
  } reg_kind_e;

  localparam logic [15:0] SHUTDOWN_CODE = 16'h000E;
  localparam logic [DATA_W-1:0] CMD_READY = 32'h0000_0001;

  function automatic reg_kind_e kind_of(input logic [MAP_W-1:0] idx);
    case (idx)
      5'd0:                       return K_GIN;
      5'd1:                       return K_GOUT;
      5'd2:                       return K_GIEN;
      5'd4, 5'd5, 5'd6,
      5'd8, 5'd9, 5'd10:          return K_TMR;
      5'd16:                      return K_CMD;
      5'd20:                      return K_SCR;
      5'd21:                      return K_LOCK;
      5'd29:                      return K_FREQ;
      5'd30:                      return K_CAPS;
      5'd31:                      return K_SYSID;
      default:                    return K_NONE;
    endcase
  endfunction

  function automatic logic is_readonly(input reg_kind_e k);
    return (k == K_GIN) || (k == K_FREQ) || (k == K_CAPS);
  endfunction

  function automatic logic is_shutdown_cmd(input logic [15:0] low_half);
    return low_half == SHUTDOWN_CODE;
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [1:0]        tmr_reg,
  output logic              tmr_group
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic             in_range;

  assign word_idx  = addr[ADDR_W-1:2];
  assign in_range  = (word_idx >> MAP_W) == '0;
  assign kind      = in_range ? kind_of(word_idx[MAP_W-1:0]) : K_NONE;
  assign tmr_reg   = word_idx[1:0];
  assign tmr_group = word_idx[3];
endmodule

// File: rtl/sysctl_gpio.sv
module sysctl_gpio #(
  parameter int               GPIO_W     = 4,
  parameter logic [GPIO_W-1:0] GPIO_STRAP = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GPIO_W-1:0] pins,
  input  logic              wr_out,
  input  logic              wr_ien,
  input  logic [GPIO_W-1:0] wdata,
  output logic [GPIO_W-1:0] gin_q,
  output logic [GPIO_W-1:0] gout_q,
  output logic [GPIO_W-1:0] gien_q,
  output logic              irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gin_q  <= GPIO_STRAP;
      gout_q <= '0;
      gien_q <= '0;
    end else begin
      gin_q <= pins;
      if (wr_out) gout_q <= wdata;
      if (wr_ien) gien_q <= wdata;
    end
  end

  assign irq = |(gin_q & gien_q);
endmodule

// File: rtl/sysctl_dbg.sv
module sysctl_dbg
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_scr,
  input  logic              wr_lock,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] scratch_q,
  output logic              lock_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
      lock_q    <= 1'b0;
    end else begin
      if (wr_scr)  scratch_q <= wdata;
      if (wr_lock) lock_q    <= 1'b1;
    end
  end
endmodule

// File: rtl/sysctl_cmd.sv
module sysctl_cmd
  import sysctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_cmd,
  input  logic        wr_sysid,
  input  logic [15:0] wdata_lo,
  output logic        shutdown_q,
  output logic        sysreset_q
);
  logic shutdown_hit;

  assign shutdown_hit = wr_cmd && is_shutdown_cmd(wdata_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shutdown_q <= 1'b0;
      sysreset_q <= 1'b0;
    end else begin
      shutdown_q <= shutdown_hit;
      sysreset_q <= wr_sysid;
    end
  end
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                GPIO_W     = 4,
  parameter logic [31:0]       SYS_ID     = 32'h1001_4D31,
  parameter logic [31:0]       CLK_FREQ   = 32'd80000000,
  parameter logic [31:0]       CAPS       = 32'h0000_0000,
  parameter logic [GPIO_W-1:0] GPIO_STRAP = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              err_strobe,
  input  logic [GPIO_W-1:0] gpio_pins,
  output logic [GPIO_W-1:0] gpio_out,
  output logic              gpio_irq,
  output logic              shutdown_req,
  output logic              sysreset_req,
  output logic              tmr_valid,
  output logic              tmr_write,
  output logic              tmr_group,
  output logic [1:0]        tmr_reg,
  output logic [31:0]       tmr_wdata,
  input  logic [31:0]       tmr_rdata
);
  reg_kind_e         kind;
  logic              wr_en, rd_en;
  logic              wr_gout, wr_gien, wr_scr, wr_lock, wr_cmd, wr_sysid;
  logic              access_err;
  logic [GPIO_W-1:0] gin_q, gout_q, gien_q;
  logic [31:0]       scratch_q;
  logic              lock_q;
  logic [31:0]       rd_mux;

  sysctl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr      (req_addr),
    .kind      (kind),
    .tmr_reg   (tmr_reg),
    .tmr_group (tmr_group)
  );

  assign wr_en    = req_valid &&  req_write;
  assign rd_en    = req_valid && !req_write;
  assign wr_gout  = wr_en && (kind == K_GOUT);
  assign wr_gien  = wr_en && (kind == K_GIEN);
  assign wr_scr   = wr_en && (kind == K_SCR);
  assign wr_lock  = wr_en && (kind == K_LOCK);
  assign wr_cmd   = wr_en && (kind == K_CMD);
  assign wr_sysid = wr_en && (kind == K_SYSID);
  assign access_err = req_valid &&
                      ((kind == K_NONE) || (req_write && is_readonly(kind)));

  assign tmr_valid = req_valid && (kind == K_TMR);
  assign tmr_write = req_write;
  assign tmr_wdata = req_wdata;

  sysctl_gpio #(.GPIO_W(GPIO_W), .GPIO_STRAP(GPIO_STRAP)) u_gpio (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins   (gpio_pins),
    .wr_out (wr_gout),
    .wr_ien (wr_gien),
    .wdata  (req_wdata[GPIO_W-1:0]),
    .gin_q  (gin_q),
    .gout_q (gout_q),
    .gien_q (gien_q),
    .irq    (gpio_irq)
  );

  sysctl_dbg u_dbg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_scr    (wr_scr),
    .wr_lock   (wr_lock),
    .wdata     (req_wdata),
    .scratch_q (scratch_q),
    .lock_q    (lock_q)
  );

  sysctl_cmd u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_cmd     (wr_cmd),
    .wr_sysid   (wr_sysid),
    .wdata_lo   (req_wdata[15:0]),
    .shutdown_q (shutdown_req),
    .sysreset_q (sysreset_req)
  );

  assign gpio_out = gout_q;

  always_comb begin
    case (kind)
      K_GIN:   rd_mux = 32'(gin_q);
      K_GOUT:  rd_mux = 32'(gout_q);
      K_GIEN:  rd_mux = 32'(gien_q);
      K_TMR:   rd_mux = tmr_rdata;
      K_CMD:   rd_mux = CMD_READY;
      K_SCR:   rd_mux = scratch_q;
      K_LOCK:  rd_mux = 32'(lock_q);
      K_FREQ:  rd_mux = CLK_FREQ;
      K_CAPS:  rd_mux = CAPS;
      K_SYSID: rd_mux = SYS_ID;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      err_strobe <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      err_strobe <= access_err;
      rsp_rdata  <= rd_en ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic              err_strobe,
  input logic              shutdown_req,
  input logic              sysreset_req,
  input logic              lock_q
);
  logic [ADDR_W-3:0] idx;
  logic              wr_cmd_code, wr_id, wr_lk;

  assign idx         = req_addr[ADDR_W-1:2];
  assign wr_cmd_code = req_valid && req_write && (idx == (ADDR_W-2)'(16)) &&
                       (req_wdata[15:0] == 16'h000E);
  assign wr_id       = req_valid && req_write && (idx == (ADDR_W-2)'(31));
  assign wr_lk       = req_valid && req_write && (idx == (ADDR_W-2)'(21));

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !err_strobe);
  // R4
  shutdown_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd_code |=> shutdown_req);
  // R4
  shutdown_only_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cmd_code |=> !shutdown_req);
  // R5
  sysreset_on_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_id |=> sysreset_req);
  // R5
  sysreset_only_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_id |=> !sysreset_req);
  // R3
  lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lk |=> lock_q);
  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  // R8
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_strobe |-> rsp_rdata == 32'h0);
endmodule

bind sysctl_regbank sysctl_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .req_addr     (req_addr),
  .req_wdata    (req_wdata),
  .rsp_valid    (rsp_valid),
  .rsp_rdata    (rsp_rdata),
  .err_strobe   (err_strobe),
  .shutdown_req (shutdown_req),
  .sysreset_req (sysreset_req),
  .lock_q       (lock_q)
);

// File: tb/sysctl_regbank_tb.sv
module sysctl_regbank_tb;
  localparam int          ADDR_W = 8;
  localparam int          GPIO_W = 4;
  localparam logic [31:0] EXP_ID   = 32'h1001_4D31;
  localparam logic [31:0] EXP_FREQ = 32'd80000000;

  typedef struct {
    logic [31:0] rdata;
    logic        err;
    logic        shut;
    logic        srst;
    string       tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              rsp_valid, err_strobe, gpio_irq, shutdown_req, sysreset_req;
  logic [31:0]       rsp_rdata, tmr_wdata, tmr_rdata;
  logic [GPIO_W-1:0] gpio_pins = '0, gpio_out;
  logic              tmr_valid, tmr_write, tmr_group;
  logic [1:0]        tmr_reg;

  int   n_checks = 0, n_fails = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #10 clk = ~clk;

  // timer block model: data names the group and register addressed
  assign tmr_rdata = 32'hA000_0000 | (32'(tmr_group) << 4) | 32'(tmr_reg);

  sysctl_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .err_strobe(err_strobe), .gpio_pins(gpio_pins),
    .gpio_out(gpio_out), .gpio_irq(gpio_irq), .shutdown_req(shutdown_req),
    .sysreset_req(sysreset_req), .tmr_valid(tmr_valid), .tmr_write(tmr_write),
    .tmr_group(tmr_group), .tmr_reg(tmr_reg), .tmr_wdata(tmr_wdata),
    .tmr_rdata(tmr_rdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive_now(input bit w, input logic [ADDR_W-1:0] a,
                           input logic [31:0] d, input logic [31:0] er,
                           input bit ee, input bit es, input bit ex,
                           input string tag);
    exp_t e;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    e.rdata = er; e.err = ee; e.shut = es; e.srst = ex; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic acc(input bit w, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                     input logic [31:0] er, input bit ee, input bit es,
                     input bit ex, input string tag);
    @(negedge clk);
    drive_now(w, a, d, er, ee, es, ex, tag);
  endtask

  task automatic rd(input int idx, input logic [31:0] er, input bit ee,
                    input string tag);
    acc(1'b0, ADDR_W'(idx * 4), 32'h0, er, ee, 1'b0, 1'b0, tag);
  endtask

  task automatic wr(input int idx, input logic [31:0] d, input bit ee,
                    input bit es, input bit ex, input string tag);
    acc(1'b1, ADDR_W'(idx * 4), d, 32'h0, ee, es, ex, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2 unexpected response", 32'(rsp_valid), 32'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(rsp_rdata === e.rdata, {e.tag, " rdata"}, rsp_rdata, e.rdata);
          check(err_strobe === e.err, {e.tag, " err"}, 32'(err_strobe), 32'(e.err));
          check(shutdown_req === e.shut, {e.tag, " shutdown"},
                32'(shutdown_req), 32'(e.shut));
          check(sysreset_req === e.srst, {e.tag, " sysreset"},
                32'(sysreset_req), 32'(e.srst));
        end
      end else begin
        check(!shutdown_req && !sysreset_req && !err_strobe,
              "R2 idle pulse", {29'h0, shutdown_req, sysreset_req, err_strobe}, 32'h0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual %h expected %h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!rsp_valid && !err_strobe && !shutdown_req && !sysreset_req &&
          !gpio_irq && gpio_out == '0, "R7 outputs in reset", 32'(rsp_valid), 32'h0);
    // release reset and read the strapped input before the pins are sampled
    rst_n = 1'b1;
    drive_now(1'b0, 8'h00, 32'h0, 32'h1, 1'b0, 1'b0, 1'b0, "R7 input strap");
    rd(31, EXP_ID, 1'b0, "R7 system id");
    rd(29, EXP_FREQ, 1'b0, "R7 frequency");
    rd(30, 32'h0, 1'b0, "R7 capabilities");
    rd(16, 32'h1, 1'b0, "R4 command ready");
    rd(21, 32'h0, 1'b0, "R3 lock after reset");
    rd(20, 32'h0, 1'b0, "R7 scratch after reset");
    rd(1, 32'h0, 1'b0, "R7 output after reset");
    rd(0, 32'h0, 1'b0, "R9 pins sampled");

    // R1 scratch and address low bits
    wr(20, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, "R1 scratch write");
    rd(20, 32'hDEAD_BEEF, 1'b0, "R1 scratch read");
    acc(1'b0, 8'h53, 32'h0, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, "R1 low bits ignored");

    // R3 lock
    wr(21, 32'h0, 1'b0, 1'b0, 1'b0, "R3 lock write zero");
    rd(21, 32'h1, 1'b0, "R3 lock set");
    wr(21, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, "R3 lock write ones");
    rd(21, 32'h1, 1'b0, "R3 lock stays");

    // R4 command pulses
    wr(16, 32'h1234_000E, 1'b0, 1'b1, 1'b0, "R4 shutdown code");
    wr(16, 32'h0000_000F, 1'b0, 1'b0, 1'b0, "R4 other code");
    wr(16, 32'h000E_0000, 1'b0, 1'b0, 1'b0, "R4 code in upper half");
    rd(16, 32'h1, 1'b0, "R4 command reads ready");

    // R5 reset request
    wr(31, 32'h0, 1'b0, 1'b0, 1'b1, "R5 reset request");
    rd(31, EXP_ID, 1'b0, "R5 id unchanged");

    // R6 read-only
    wr(0, 32'hF, 1'b1, 1'b0, 1'b0, "R6 write input");
    wr(29, 32'h0, 1'b1, 1'b0, 1'b0, "R6 write frequency");
    wr(30, 32'h5, 1'b1, 1'b0, 1'b0, "R6 write capabilities");
    rd(29, EXP_FREQ, 1'b0, "R6 frequency kept");
    rd(30, 32'h0, 1'b0, "R6 capabilities kept");
    rd(0, 32'h0, 1'b0, "R6 input kept");

    // R8 unmapped
    wr(3, 32'h55, 1'b1, 1'b0, 1'b0, "R8 write idx3");
    rd(3, 32'h0, 1'b1, "R8 read idx3");
    rd(7, 32'h0, 1'b1, "R8 read idx7");
    wr(11, 32'h1, 1'b1, 1'b0, 1'b0, "R8 write idx11");
    acc(1'b0, 8'h80, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0, "R8 index 32");
    acc(1'b1, 8'hD0, 32'h1, 32'h0, 1'b1, 1'b0, 1'b0, "R8 write aliased 20");
    rd(20, 32'hDEAD_BEEF, 1'b0, "R8 scratch untouched");

    // R9 / R10 gpio
    wr(1, 32'hA, 1'b0, 1'b0, 1'b0, "R9 output write");
    idle(1);
    check(gpio_out == 4'hA, "R9 gpio_out", 32'(gpio_out), 32'hA);
    rd(1, 32'hA, 1'b0, "R9 output read");
    gpio_pins = 4'h5;
    idle(2);
    rd(0, 32'h5, 1'b0, "R9 input follows pins");
    check(gpio_irq == 1'b0, "R10 irq no enable", 32'(gpio_irq), 32'h0);
    wr(2, 32'h4, 1'b0, 1'b0, 1'b0, "R10 enable bit2");
    idle(1);
    check(gpio_irq == 1'b1, "R10 irq on", 32'(gpio_irq), 32'h1);
    wr(2, 32'h8, 1'b0, 1'b0, 1'b0, "R10 enable bit3");
    idle(1);
    check(gpio_irq == 1'b0, "R10 irq off", 32'(gpio_irq), 32'h0);

    // R11 timer forwarding
    rd(5, 32'hA000_0001, 1'b0, "R11 timer group0 reg1");
    #1 check(tmr_valid && !tmr_write && !tmr_group && tmr_reg == 2'd1,
             "R11 forward 5", {28'h0, tmr_valid, tmr_group, tmr_reg}, 32'h9);
    rd(9, 32'hA000_0011, 1'b0, "R11 timer group1 reg1");
    wr(10, 32'h77, 1'b0, 1'b0, 1'b0, "R11 timer write");
    #1 check(tmr_valid && tmr_write && tmr_group && tmr_reg == 2'd2 &&
             tmr_wdata == 32'h77, "R11 forward write", tmr_wdata, 32'h77);
    idle(1);
    #1 check(!tmr_valid, "R11 idle", 32'(tmr_valid), 32'h0);
    idle(2);

    // reset clears the lock
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    rd(21, 32'h0, 1'b0, "R3 lock cleared by reset");
    rd(20, 32'h0, 1'b0, "R7 scratch cleared by reset");
    idle(3);
    check(gpio_out == '0, "R7 output cleared", 32'(gpio_out), 32'h0);
    check(sb.size() == 0, "R2 responses drained", 32'(sb.size()), 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule